// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block multiplies two fixed-point operands and either loads the product into a wide accumulator or adds it to or subtracts it from the running total. Each operand has its own select that marks it as two's-complement or unsigned. A mode input chooses how the product is read: as an integer, with the binary point right of the LSB, or as a fraction, with the binary point just left of the top magnitude bit. When both operands are signed and the mode is fractional, the product is shifted left by one bit. The shift removes the duplicated sign bit and puts the upper product word back into fractional form.

The accumulator has headroom above the product width, so many products can be summed before anything is lost. A sticky flag records a signed overflow of the accumulator. A second flag marks the single signed product that cannot be represented after the fractional shift: the most negative value multiplied by itself. Operations are qualified by a valid strobe. The result appears at the outputs one clock after the operation is accepted.

Top module: `fxmac_unit`

## Requirements
- R1: After reset the accumulator output is zero and both flags are low.
- R2: When both operands are unsigned, the product is the full-width unsigned product, zero-extended to the accumulator width. It is not shifted in either mode.
- R3: When exactly one operand is signed, the product is the two's-complement product, sign-extended to the accumulator width and not shifted.
- R4: When both operands are signed and `frac_i` is 0 (integer mode), the product is the two's-complement product, sign-extended and not shifted.
- R5: When both operands are signed and `frac_i` is 1, the product is shifted left by one bit before it is sign-extended. Bit 62 becomes bit 63 and the LSB is 0.
- R6: `fsn_o` is 1 after an accepted operation only when both operands are signed, `frac_i` is 1 and both operands hold the most negative value. Every accepted load, add or subtract operation updates `fsn_o`.
- R7: `op_i` encoding: 00 loads the extended product, 01 adds it to the accumulator, 10 subtracts it from the accumulator, and 11 leaves the accumulator and both flags unchanged. The result is visible one clock after the edge that accepts the operation.
- R8: While `valid_i` is 0, the accumulator and both flags keep their values.
- R9: The accumulator is an `ACC_W`-bit two's-complement value. It wraps on overflow. `ovf_o` is set when an add or subtract produces a true result outside that range.
- R10: `ovf_o` stays set through later add, subtract and hold operations. A load (op 00) clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accepts the operation on this cycle |
| op_i | input | 2 | Operation code: 00 load, 01 add, 10 subtract, 11 hold |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| a_signed_i | input | 1 | First operand is two's-complement |
| b_signed_i | input | 1 | Second operand is two's-complement |
| frac_i | input | 1 | 1 selects fractional interpretation, 0 selects integer |
| acc_o | output | ACC_W | Accumulator value |
| ovf_o | output | 1 | Sticky accumulator overflow |
| fsn_o | output | 1 | Last product was most-negative squared in fractional mode |

## Verification
The product path is swept over every operand pair, all four signedness combinations and both modes on a narrow configuration. Each result is loaded and compared with an arithmetic model. This separates zero extension from sign extension, shows that the shift is tied to signed-by-signed fractional products only, and confirms that the most-negative-squared flag fires on that one combination alone. A directed accumulation sequence then drives the total past the positive and negative limits, interleaves hold and idle cycles, and reloads. These steps expose the wrap, the stickiness of the overflow flag and the way a load clears it.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
   typedef enum logic [1:0] {
      OP_LOAD = 2'b00,
      OP_ADD  = 2'b01,
      OP_SUB  = 2'b10,
      OP_HOLD = 2'b11
   } fxmac_op_e;
endpackage

// File: rtl/fxmac_mul.sv
// Multiplies two operands, each one independently signed or unsigned.
module fxmac_mul #(
   parameter int DATA_W = 32,
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              a_signed,
   input  logic              b_signed,
   output logic [PROD_W-1:0] prod,
   output logic              prod_signed
);
   logic signed [DATA_W:0]   a_x;
   logic signed [DATA_W:0]   b_x;
   logic signed [PROD_W+1:0] full;

   // One guard bit per operand lets one signed multiplier cover all four cases
   assign a_x         = {a_signed & a[DATA_W-1], a};
   assign b_x         = {b_signed & b[DATA_W-1], b};
   assign full        = a_x * b_x;
   assign prod        = full[PROD_W-1:0];
   assign prod_signed = a_signed | b_signed;
endmodule

// File: rtl/fxmac_norm.sv
// Applies the one-bit left shift to signed-by-signed fractional products.
module fxmac_norm #(
   parameter int DATA_W = 32,
   parameter bit SHIFT_EN = 1'b1,
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic [PROD_W-1:0] prod_in,
   input  logic              both_signed,
   input  logic              frac,
   output logic [PROD_W-1:0] prod_out,
   output logic              fsn
);
   generate
      if (SHIFT_EN) begin : g_shift
         logic do_shift;
         assign do_shift = both_signed & frac;
         assign prod_out = do_shift ? {prod_in[PROD_W-2:0], 1'b0} : prod_in;
         // The two top bits differ only for most-negative squared
         assign fsn      = do_shift & (prod_in[PROD_W-1] ^ prod_in[PROD_W-2]);
      end else begin : g_pass
         assign prod_out = prod_in;
         assign fsn      = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fxmac_acc.sv
// Extends the product and holds the wrapping accumulator and its flags.
module fxmac_acc
   import fxmac_pkg::*;
#(
   parameter int PROD_W = 64,
   parameter int ACC_W  = 80,
   localparam int EXT_W = ACC_W - PROD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [1:0]        op,
   input  logic [PROD_W-1:0] prod,
   input  logic              prod_signed,
   input  logic              fsn_in,
   output logic [ACC_W-1:0]  acc,
   output logic              ovf,
   output logic              fsn
);
   logic [ACC_W-1:0] ext;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] dif;
   logic             ovf_add;
   logic             ovf_sub;
   fxmac_op_e        op_e;

   assign op_e = fxmac_op_e'(op);
   assign ext  = {{EXT_W{prod_signed & prod[PROD_W-1]}}, prod};
   assign sum  = acc + ext;
   assign dif  = acc - ext;

   // Signed overflow: the operand signs permit it and the result sign breaks it
   assign ovf_add = (acc[ACC_W-1] == ext[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
   assign ovf_sub = (acc[ACC_W-1] != ext[ACC_W-1]) && (dif[ACC_W-1] != acc[ACC_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
         fsn <= 1'b0;
      end else if (valid) begin
         case (op_e)
            OP_LOAD: begin
               acc <= ext;
               ovf <= 1'b0;
               fsn <= fsn_in;
            end
            OP_ADD: begin
               acc <= sum;
               ovf <= ovf | ovf_add;
               fsn <= fsn_in;
            end
            OP_SUB: begin
               acc <= dif;
               ovf <= ovf | ovf_sub;
               fsn <= fsn_in;
            end
            default: begin
               acc <= acc;
               ovf <= ovf;
               fsn <= fsn;
            end
         endcase
      end
   end
endmodule

// File: rtl/fxmac_unit.sv
module fxmac_unit #(
   parameter int DATA_W   = 32,
   parameter int ACC_W    = 80,
   parameter bit SHIFT_EN = 1'b1,
   localparam int PROD_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              a_signed_i,
   input  logic              b_signed_i,
   input  logic              frac_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic              ovf_o,
   output logic              fsn_o
);
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("fxmac_unit: DATA_W must be at least 2");
      end
      if (ACC_W <= PROD_W) begin : g_bad_acc
         $error("fxmac_unit: ACC_W must exceed twice DATA_W");
      end
   endgenerate

   logic [PROD_W-1:0] raw_prod;
   logic [PROD_W-1:0] norm_prod;
   logic              prod_signed;
   logic              fsn_now;

   fxmac_mul #(.DATA_W(DATA_W)) u_mul (
      .a           (a_i),
      .b           (b_i),
      .a_signed    (a_signed_i),
      .b_signed    (b_signed_i),
      .prod        (raw_prod),
      .prod_signed (prod_signed)
   );

   fxmac_norm #(.DATA_W(DATA_W), .SHIFT_EN(SHIFT_EN)) u_norm (
      .prod_in     (raw_prod),
      .both_signed (a_signed_i & b_signed_i),
      .frac        (frac_i),
      .prod_out    (norm_prod),
      .fsn         (fsn_now)
   );

   fxmac_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (valid_i),
      .op          (op_i),
      .prod        (norm_prod),
      .prod_signed (prod_signed),
      .fsn_in      (fsn_now),
      .acc         (acc_o),
      .ovf         (ovf_o),
      .fsn         (fsn_o)
   );
endmodule

// File: rtl/fxmac_unit_chk.sv
module fxmac_unit_chk #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 80,
   localparam int PROD_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_i,
   input logic [1:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              a_signed_i,
   input logic              b_signed_i,
   input logic              frac_i,
   input logic [ACC_W-1:0]  acc_o,
   input logic              ovf_o,
   input logic              fsn_o
);
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(acc_o) && $stable(ovf_o) && $stable(fsn_o))); // R8

   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 2'b11) |=> ($stable(acc_o) && $stable(ovf_o) && $stable(fsn_o))); // R7

   AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 2'b00) |=> !ovf_o); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !(valid_i && op_i == 2'b00)) |=> ovf_o); // R10

   AST_FSN_NEEDS_SIGNED_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i != 2'b11 && !(a_signed_i && b_signed_i && frac_i)) |=> !fsn_o); // R6

   AST_FSN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i != 2'b11 && a_signed_i && b_signed_i && frac_i &&
       a_i == MOST_NEG && b_i == MOST_NEG) |=> fsn_o); // R6

   AST_UNSIGNED_LOAD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 2'b00 && !a_signed_i && !b_signed_i)
      |=> (acc_o[ACC_W-1:PROD_W] == '0)); // R2
endmodule

bind fxmac_unit fxmac_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_i    (valid_i),
   .op_i       (op_i),
   .a_i        (a_i),
   .b_i        (b_i),
   .a_signed_i (a_signed_i),
   .b_signed_i (b_signed_i),
   .frac_i     (frac_i),
   .acc_o      (acc_o),
   .ovf_o      (ovf_o),
   .fsn_o      (fsn_o)
);

// File: tb/fxmac_unit_test.sv
module fxmac_unit_test;
   localparam int DW = 4;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic [1:0]    op_i = 2'b00;
   logic [DW-1:0] a_i = '0;
   logic [DW-1:0] b_i = '0;
   logic          a_signed_i = 1'b0;
   logic          b_signed_i = 1'b0;
   logic          frac_i = 1'b0;
   logic [AW-1:0] acc_o;
   logic          ovf_o;
   logic          fsn_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference model state
   int m_acc = 0;
   bit m_ovf = 1'b0;
   bit m_fsn = 1'b0;

   always #10 clk = ~clk;

   fxmac_unit #(.DATA_W(DW), .ACC_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .a_signed_i(a_signed_i), .b_signed_i(b_signed_i),
      .frac_i(frac_i), .acc_o(acc_o), .ovf_o(ovf_o), .fsn_o(fsn_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int sval(input int x, input bit s);
      return (s && x >= 8) ? x - 16 : x;
   endfunction

   // Extended product value as a signed integer within the accumulator range
   function automatic int ext_val(input int a, input int b, input bit sa,
                                  input bit sb, input bit fr);
      int p;
      int pat;
      p = sval(a, sa) * sval(b, sb);
      if (fr && sa && sb) p = p * 2;
      pat = p & 255;
      if ((sa || sb) && pat >= 128) pat = pat - 256;
      return pat;
   endfunction

   task automatic drive(input int op, input int a, input int b, input bit sa,
                        input bit sb, input bit fr);
      @(negedge clk);
      op_i = op[1:0]; a_i = a[DW-1:0]; b_i = b[DW-1:0];
      a_signed_i = sa; b_signed_i = sb; frac_i = fr; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   // Applies one operation to the model, then to the design, and compares
   task automatic acc_op(input string req, input int op, input int a, input int b,
                         input bit sa, input bit sb, input bit fr);
      int e;
      int t;
      e = ext_val(a, b, sa, sb, fr);
      t = m_acc;
      if (op != 3) m_fsn = fr && sa && sb && a == 8 && b == 8;
      if (op == 0) begin t = e; m_ovf = 1'b0; end
      else if (op == 1) t = m_acc + e;
      else if (op == 2) t = m_acc - e;
      if (t > 511 || t < -512) m_ovf = 1'b1;
      t = ((t % 1024) + 1024) % 1024;
      if (t >= 512) t = t - 1024;
      m_acc = t;
      drive(op, a, b, sa, sb, fr);
      chk({req, " acc"}, int'(acc_o), m_acc & 1023);
      chk({req, " ovf"}, int'(ovf_o), int'(m_ovf));
      chk({req, " fsn"}, int'(fsn_o), int'(m_fsn));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 acc", int'(acc_o), 0);
      chk("R1 ovf", int'(ovf_o), 0);
      chk("R1 fsn", int'(fsn_o), 0);
      rst_n = 1'b1;

      // Sweep: every pair, signedness and mode, loaded with op 00 (R7)
      for (int m = 0; m < 8; m++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               bit sa;
               bit sb;
               bit fr;
               string req;
               sa = m[0]; sb = m[1]; fr = m[2];
               if (!sa && !sb) req = "R2";
               else if (sa != sb) req = "R3";
               else if (!fr) req = "R4";
               else req = "R5";
               drive(0, a, b, sa, sb, fr);
               chk({req, " R7 load"}, int'(acc_o), ext_val(a, b, sa, sb, fr) & 1023);
               chk("R6 fsn", int'(fsn_o), int'(fr && sa && sb && a == 8 && b == 8));
               chk("R10 load ovf", int'(ovf_o), 0);
            end
         end
      end
      m_acc = ext_val(15, 15, 1'b1, 1'b1, 1'b1);
      m_fsn = 1'b0;
      m_ovf = 1'b0;

      // Positive overflow and stickiness
      acc_op("R7 load", 0, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R7 add", 1, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R9 add overflow", 1, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R10 sticky add", 1, 8, 7, 1'b1, 1'b1, 1'b0);
      acc_op("R6 fsn via add", 1, 8, 8, 1'b1, 1'b1, 1'b1);
      acc_op("R7 hold", 3, 15, 15, 1'b0, 1'b0, 1'b0);

      // R8: idle cycles with changing inputs
      @(negedge clk);
      op_i = 2'b01; a_i = 4'd15; b_i = 4'd15; frac_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 idle acc", int'(acc_o), m_acc & 1023);
      chk("R8 idle ovf", int'(ovf_o), int'(m_ovf));
      chk("R8 idle fsn", int'(fsn_o), int'(m_fsn));

      // Negative overflow after a clearing load
      acc_op("R10 load clears", 0, 8, 7, 1'b1, 1'b1, 1'b0);
      acc_op("R7 sub", 2, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R7 sub", 2, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R9 sub overflow", 2, 15, 15, 1'b0, 1'b0, 1'b0);
      acc_op("R10 sticky sub", 2, 1, 1, 1'b0, 1'b0, 1'b0);
      acc_op("R3 mixed add", 1, 15, 9, 1'b0, 1'b1, 1'b1);
      acc_op("R10 reload", 0, 3, 5, 1'b1, 1'b0, 1'b0);
      acc_op("R5 frac add", 1, 7, 12, 1'b1, 1'b1, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule